// File: doc/BRIEF.md
# Power-Down Control Register Unit

This unit holds the byte-wide power-management register of a mixed-signal audio device, together with an index/data register pair that reaches nine secondary control bytes. A simple host bus writes and reads these registers. The unit turns the power byte into enables for each subsystem, and it also drives the following:

- a sleep state for the embedded processor;
- a one-cycle request that starts calibration;
- a forced mixer-bypass override;
- a flag that pins the sample rate to 44.1 kHz.

Some parts are outside the unit: the analog blocks, the calibration engine, the processor and the mixer's own bypass bit. They appear only as inputs: a calibration-done strobe, three processor-interface access strobes and the mixer's requested bypass value. The host address map has four slots:

| Address | Register |
|---|---|
| 0 | Power byte |
| 1 | Index register |
| 2 | Data window |
| 3 | Unused; reads 0x00, writes are dropped |

Reads are combinational: `bus_rdata` reflects the addressed register while `bus_rd` is high and is 0x00 otherwise. Writes take effect at the clock edge.

Top module: `pwr_ctl_unit`

## Requirements
- R1: After reset, the power byte, the index and all nine control bytes are 0x00. All outputs are low.
- R2: The power byte at address 0 reads back as written. Its bit assignments are listed below. While bit 7 is set, every power-down output is high.

  | Bit | Function |
  |---|---|
  | 7 | Global power-down |
  | 6 | Rate converter |
  | 5 | Reference |
  | 4 | Mixer |
  | 3 | ADC |
  | 2 | DAC and serial ports |
  | 1 | Processor idle |
  | 0 | FM synthesizer |

- R3: While global power-down is set, writes to addresses 1 and 2 are dropped and reads of addresses 1 and 2 return 0x00. The power byte stays readable and writable, and the control bytes keep their values.
- R4: A write that clears bit 7 while it is set makes `cal_start` high for exactly the next cycle. The same write sets `cal_pending`, which stays high until `cal_done` is seen.
- R5: A write that sets bit 7 while `cal_pending` is high cancels the pending calibration. `cal_pending` is low from the next cycle.
- R6: Writing the power byte with bit 1 set makes `proc_sleep` high. An access strobe on any `proc_hit` line, with global power-down clear, makes it low again from the next cycle. A same-cycle write that puts the processor to sleep takes priority over the strobe.
- R7: `proc_sleep` is high whenever global power-down is set. After global power-down is cleared, it stays high until a `proc_hit` strobe arrives.
- R8: `mix_bypass` is high when the mixer bit is 1 and the reference bit is 0. Otherwise it follows `byp_req`.
- R9: `pd_fm` is high when bit 0 or bit 2 is set. `pd_dac`, which covers the converters and serial ports, is high when bit 2 is set.
- R10: Setting bit 5 raises `pd_ref`, `pd_mix`, `pd_adc`, `pd_dac` and `pd_fm` together.
- R11: `rate_lock` (sample rate restricted to 44.1 kHz) equals bit 6. `pd_src` is high when bit 6 or bit 7 is set.
- R12: Only the low 4 bits of a write to the index register are kept; they select control byte C0 to C8. The upper 4 bits are ignored and read back as 0. Address 2 reads and writes the selected byte. Control byte Cn appears on `ctrl_regs[8n+7:8n]`.
- R13: An index of 9 to 15 makes address 2 read 0x00, and writes through address 2 with such an index are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when not reading |
| proc_hit | input | 3 | Access strobes from the sound-emulation, MIDI and plug-and-play interfaces |
| cal_done | input | 1 | Calibration finished |
| byp_req | input | 1 | Mixer's own bypass value |
| pd_global | output | 1 | Global power-down |
| pd_src | output | 1 | Rate-converter power-down |
| pd_ref | output | 1 | Reference power-down |
| pd_mix | output | 1 | Mixer power-down |
| pd_adc | output | 1 | ADC power-down |
| pd_dac | output | 1 | DAC and serial-port power-down |
| pd_fm | output | 1 | FM synthesizer power-down |
| proc_sleep | output | 1 | Processor held idle |
| cal_start | output | 1 | One-cycle calibration request |
| cal_pending | output | 1 | Calibration requested and not yet done |
| mix_bypass | output | 1 | Mixer bypass after override |
| rate_lock | output | 1 | Sample rate restricted to 44.1 kHz |
| ctrl_regs | output | 72 | Control bytes C0..C8, packed |

## Verification
The bench covers the following corner cases:

- **Leaving global power-down.** A design that fires `cal_start` on the wrong edge, or for more than one cycle, is caught. So is one that releases the processor without an access strobe.
- **Re-entering global power-down before `cal_done`.** This exposes a design that leaves a stale calibration request pending.
- **Accesses while globally powered down.** These catch a design that lets index or data writes through, or leaks register contents on reads.
- **Index handling.** Indexes with nonzero upper bits and indexes 9 to 15 catch a design that keeps the reserved bits, or that aliases the out-of-range slots onto real control bytes.
- **Bypass override.** Mixer and reference combinations, with `byp_req` toggled, catch an override tied to the wrong polarity of the reference bit.

// File: rtl/pwr_ctl_unit.sv
module pwr_ctl_unit #(
  parameter int NREG = 9,
  parameter int IDXW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [2:0]         proc_hit,
  input  logic               cal_done,
  input  logic               byp_req,
  output logic               pd_global,
  output logic               pd_src,
  output logic               pd_ref,
  output logic               pd_mix,
  output logic               pd_adc,
  output logic               pd_dac,
  output logic               pd_fm,
  output logic               proc_sleep,
  output logic               cal_start,
  output logic               cal_pending,
  output logic               mix_bypass,
  output logic               rate_lock,
  output logic [8*NREG-1:0]  ctrl_regs
);
  localparam logic [1:0] A_PWR = 2'd0;
  localparam logic [1:0] A_IDX = 2'd1;
  localparam logic [1:0] A_DAT = 2'd2;

  logic [7:0]      pwr;
  logic [IDXW-1:0] idx;
  logic [7:0]      cr [NREG];
  logic            sleep_q;

  wire g      = pwr[7];
  wire wr_pwr = bus_wr && bus_addr == A_PWR;
  wire wr_idx = bus_wr && bus_addr == A_IDX && !g;
  wire wr_dat = bus_wr && bus_addr == A_DAT && !g;
  wire idx_ok = 32'(idx) < NREG;
  wire clr_g  = wr_pwr && g && !bus_wdata[7];
  wire set_g  = wr_pwr && !g && bus_wdata[7];
  wire hit    = (|proc_hit) && !g;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr         <= '0;
      idx         <= '0;
      sleep_q     <= 1'b0;
      cal_start   <= 1'b0;
      cal_pending <= 1'b0;
      for (int i = 0; i < NREG; i++) cr[i] <= '0;
    end else begin
      if (wr_pwr) pwr <= bus_wdata;
      if (wr_idx) idx <= bus_wdata[IDXW-1:0];
      for (int i = 0; i < NREG; i++)
        if (wr_dat && 32'(idx) == i) cr[i] <= bus_wdata;
      cal_start <= clr_g;
      if (clr_g)         cal_pending <= 1'b1;
      else if (set_g)    cal_pending <= 1'b0;
      else if (cal_done) cal_pending <= 1'b0;
      if (wr_pwr && (bus_wdata[1] || clr_g)) sleep_q <= 1'b1;
      else if (hit)                          sleep_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_PWR:   bus_rdata = pwr;
        A_IDX:   bus_rdata = g ? 8'h00 : 8'(idx);
        A_DAT:   bus_rdata = (g || !idx_ok) ? 8'h00 : cr[idx];
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_flat
      assign ctrl_regs[8*gi +: 8] = cr[gi];
    end
  endgenerate

  assign pd_global  = g;
  assign pd_ref     = pwr[5] | g;
  assign pd_mix     = pwr[4] | pd_ref;
  assign pd_adc     = pwr[3] | pd_ref;
  assign pd_dac     = pwr[2] | pd_ref;
  assign pd_fm      = pwr[0] | pd_dac;
  assign pd_src     = pwr[6] | g;
  assign rate_lock  = pwr[6];
  assign mix_bypass = (pwr[4] & ~pwr[5]) | byp_req;
  assign proc_sleep = sleep_q | g;
endmodule

// File: rtl/pwr_ctl_unit_chk.sv
module pwr_ctl_unit_chk #(
  parameter int NREG = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [2:0]        proc_hit,
  input logic              pd_global,
  input logic              pd_ref,
  input logic              pd_mix,
  input logic              pd_adc,
  input logic              pd_dac,
  input logic              pd_fm,
  input logic              proc_sleep,
  input logic              cal_start,
  input logic              cal_pending,
  input logic              mix_bypass,
  input logic [8*NREG-1:0] ctrl_regs
);
  wire pwr_clear = bus_wr && bus_addr == 2'd0 && pd_global && !bus_wdata[7];

  a_r4_cal_request: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_clear |=> (cal_start && cal_pending && !pd_global));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_pending && bus_wr && bus_addr == 2'd0 && bus_wdata[7]) |=> !cal_pending);
  a_r7_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_clear |=> proc_sleep);
  a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ((|proc_hit) && !pd_global && !(bus_wr && bus_addr == 2'd0)) |=> !proc_sleep);
  a_r3_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_global && bus_rd && bus_addr != 2'd0) |-> bus_rdata == 8'h00);
  a_r3_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_global && bus_wr && bus_addr != 2'd0) |=> $stable(ctrl_regs));
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mix && !pd_ref) |-> mix_bypass);
  a_r9_fm_follows_dac: assert property (@(posedge clk) disable iff (!rst_n)
    pd_dac |-> pd_fm);
  a_r10_ref_all: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ref |-> (pd_mix && pd_adc && pd_dac && pd_fm));
endmodule

bind pwr_ctl_unit pwr_ctl_unit_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/tb_pwr_ctl_unit.sv
module tb_pwr_ctl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  proc_hit = '0;
  logic        cal_done = 1'b0, byp_req = 1'b0;
  logic        pd_global, pd_src, pd_ref, pd_mix, pd_adc, pd_dac, pd_fm;
  logic        proc_sleep, cal_start, cal_pending, mix_bypass, rate_lock;
  logic [71:0] ctrl_regs;

  pwr_ctl_unit dut (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  bit [7:0] m_pwr;
  int       m_idx;
  bit [7:0] m_cr [9];
  bit       m_sleep, m_cs, m_pend;

  task automatic m_reset();
    m_pwr = 0; m_idx = 0; m_sleep = 0; m_cs = 0; m_pend = 0;
    foreach (m_cr[i]) m_cr[i] = 0;
  endtask

  function automatic bit [7:0] exp_rd();
    bit gl = m_pwr[7];
    if (!bus_rd) return 8'h00;
    if (bus_addr == 0) return m_pwr;
    if (gl) return 8'h00;
    if (bus_addr == 1) return 8'(m_idx);
    if (bus_addr == 2) return (m_idx < 9) ? m_cr[m_idx] : 8'h00;
    return 8'h00;
  endfunction

  task automatic m_step();
    bit gl = m_pwr[7];
    bit wp = bus_wr && bus_addr == 0;
    bit clr = wp && gl && !bus_wdata[7];
    bit st = wp && !gl && bus_wdata[7];
    m_cs = clr;
    if (clr) m_pend = 1; else if (st || cal_done) m_pend = 0;
    if (wp && (bus_wdata[1] || clr)) m_sleep = 1;
    else if (proc_hit != 0 && !gl) m_sleep = 0;
    if (!gl && bus_wr && bus_addr == 1) m_idx = int'(bus_wdata[3:0]);
    if (!gl && bus_wr && bus_addr == 2 && m_idx < 9) m_cr[m_idx] = bus_wdata;
    if (wp) m_pwr = bus_wdata;
  endtask

  task automatic cmp(string what, logic [71:0] act, logic [71:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_outs();
    bit gl = m_pwr[7];
    bit r = m_pwr[5] | gl;
    bit d = m_pwr[2] | r;
    logic [11:0] e, a;
    logic [71:0] ecr;
    e = {gl, m_pwr[6] | gl, r, m_pwr[4] | r, m_pwr[3] | r, d, m_pwr[0] | d,
         m_sleep | gl, m_cs, m_pend, (m_pwr[4] & ~m_pwr[5]) | byp_req, m_pwr[6]};
    a = {pd_global, pd_src, pd_ref, pd_mix, pd_adc, pd_dac, pd_fm,
         proc_sleep, cal_start, cal_pending, mix_bypass, rate_lock};
    for (int i = 0; i < 9; i++) ecr[8*i +: 8] = m_cr[i];
    cmp("outputs", 72'(a), 72'(e));
    cmp("ctrl_regs", ctrl_regs, ecr);
  endtask

  task automatic cyc(input logic [1:0] a, input logic w, input logic rd,
                     input logic [7:0] d, input logic [2:0] h = 0,
                     input logic dn = 0);
    bus_addr = a; bus_wr = w; bus_rd = rd; bus_wdata = d; proc_hit = h; cal_done = dn;
    #1;
    cmp("rdata", 72'(bus_rdata), 72'(exp_rd()));
    @(posedge clk);
    m_step();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; proc_hit = 0; cal_done = 0;
    check_outs();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(a, 1, 0, d); endtask
  task automatic rd(input logic [1:0] a); cyc(a, 0, 1, 8'h00); endtask
  task automatic idle(); cyc(0, 0, 0, 8'h00); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; check_outs(); idle(); rd(0); rd(1); rd(2);

    cur_req = "R12";
    for (int i = 0; i < 9; i++) begin
      wr(1, 8'(i)); wr(2, 8'(8'hA0 + i * 7)); rd(2);
    end
    wr(1, 8'hF5); rd(1); rd(2); wr(2, 8'h3C); rd(2);
    cur_req = "R13";
    wr(1, 8'h09); rd(2); wr(2, 8'hFF); rd(2);
    wr(1, 8'h0F); wr(2, 8'h77); rd(2); rd(3); wr(3, 8'h55); rd(3);

    cur_req = "R2";  wr(0, 8'h08); rd(0); wr(0, 8'h02); rd(0); wr(0, 8'h00);
    cur_req = "R9";  wr(0, 8'h01); wr(0, 8'h04); wr(0, 8'h05); wr(0, 8'h00);
    cur_req = "R8";  wr(0, 8'h10); byp_req = 1; idle(); byp_req = 0;
    wr(0, 8'h30); byp_req = 1; idle(); byp_req = 0; idle(); wr(0, 8'h00);
    cur_req = "R10"; wr(0, 8'h20); rd(0);
    cur_req = "R11"; wr(0, 8'h40); wr(0, 8'h00);

    cur_req = "R6";
    wr(0, 8'h02); idle(); cyc(0, 0, 0, 0, 3'b001); cyc(0, 0, 0, 0, 3'b010);
    wr(0, 8'h00); cyc(0, 1, 0, 8'h02, 3'b100); cyc(0, 0, 0, 0, 3'b100);

    cur_req = "R3";
    wr(1, 8'h04); wr(0, 8'h80); rd(0); rd(1); rd(2);
    wr(1, 8'h02); wr(2, 8'hEE); cyc(0, 0, 0, 0, 3'b111);
    cur_req = "R2"; wr(0, 8'hFF); rd(0); wr(0, 8'h80);
    cur_req = "R4"; wr(0, 8'h00); idle(); idle(); cyc(0, 0, 0, 0, 3'b000, 1); idle();
    cur_req = "R7"; idle(); cyc(0, 0, 0, 0, 3'b010); rd(1); rd(2);

    cur_req = "R5";
    wr(0, 8'h80); wr(0, 8'h00); idle(); wr(0, 8'h80); idle(); wr(0, 8'h00);
    cyc(0, 0, 0, 0, 3'b000, 1); idle();

    cur_req = "R12";
    for (int k = 0; k < 300; k++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      if (a == 0 && ($urandom_range(0, 3) != 0)) d[7] = 1'b0;
      byp_req = 1'($urandom);
      cyc(a, 1'($urandom), 1'($urandom), d, 3'($urandom_range(0, 7) == 0 ? 1 : 0),
          1'($urandom_range(0, 5) == 0));
    end

    summary();
    $finish;
  end
endmodule